// File: doc/BRIEF.md
# Eight-Lane Maximum Value and Position Finder

This block receives eight unsigned words at once and reports the largest of them together with the lane number (0 to 7) where that word sits. Lane `i` occupies bits `[i*W +: W]` of the flat input bus `in_vals`. A set of words is offered by raising `in_valid` for one clock. The result appears on `out_max` and `out_idx` while `out_valid` is high for one cycle.

A build-time parameter picks one of two implementations behind the same ports. The default is a three-level pipelined reduction tree. Each tree node compares two value/position pairs and passes on the winner, and a register stage separates the levels, so the tree accepts a new set every cycle. The alternative is a compact serial scanner. It visits one lane per clock and keeps a running best value and its position, so each result takes eight clocks. In both variants a tie goes to the lower-numbered lane.

Top module: `maxidx_top`

## Requirements
- R1: When a set is accepted, the `out_max` value reported for it is the largest of the eight lanes, compared as unsigned `W`-bit numbers. Lane `i` is `in_vals[i*W +: W]`.
- R2: The `out_idx` value reported with a result is the lane number (0 to 7) of a lane that holds the value on `out_max`.
- R3: When two or more lanes share the largest value, `out_idx` names the lowest-numbered of those lanes. An all-equal set, including all zeros, therefore reports lane 0.
- R4: With `SEQUENTIAL`=0, `out_valid` rises in the cycle after the third rising edge, counting the edge that sampled `in_valid` high. That result belongs to the sampled set.
- R5: With `SEQUENTIAL`=0, sets offered on consecutive cycles each produce their own correct result, on consecutive cycles and in the order they were offered.
- R6: With `SEQUENTIAL`=0, `out_valid` is low in every cycle that does not correspond, under R4, to an accepted set.
- R7: With `SEQUENTIAL`=1, an idle scanner accepts `in_valid`. The caller holds `in_vals` stable across eight rising edges, counting the accepting edge. `out_valid` is then high for exactly one cycle after the eighth edge, and low otherwise.
- R8: With `SEQUENTIAL`=1, `in_valid` has no effect while a scan is running. A new set can be accepted on the edge at which `out_valid` is high.
- R9: With `SEQUENTIAL`=1, every scan starts from the smallest value. A large earlier result never carries over, so an all-zero set reports 0 at lane 0.
- R10: After reset, `out_valid` is low, and `out_max` and `out_idx` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Offer the set on `in_vals` |
| in_vals | input | 8*W | Eight lanes, lane `i` at bits `[i*W +: W]` |
| out_valid | output | 1 | Result strobe, one cycle per accepted set |
| out_max | output | W | Largest lane value |
| out_idx | output | 3 | Lane number holding the largest value |

## Verification
Both variants are driven with the same kinds of set. A rising ramp and a falling ramp catch a comparator that points the wrong way. Equal lanes, all zeros and all ones catch a tie rule that favours the upper lane. A winner that differs from its neighbours only in the lowest bit, or that sits at full scale next to a value one below it, catches a truncated or signed comparison. Two equal peaks at lanes 3 and 6 check that the position travels with the value through every stage. Random back-to-back sets with idle gaps check that the tree's results stay lined up with their inputs, and the scanner is fed spurious `in_valid` pulses in mid-scan and an all-zero set right after an all-ones set.

// File: rtl/maxidx_pkg.sv
package maxidx_pkg;
    localparam int LANES = 8;
    localparam int IDX_W = $clog2(LANES);
endpackage

// File: rtl/maxidx_node.sv
module maxidx_node
    import maxidx_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0]     a_val,
    input  logic [IDX_W-1:0] a_idx,
    input  logic [W-1:0]     b_val,
    input  logic [IDX_W-1:0] b_idx,
    output logic [W-1:0]     w_val,
    output logic [IDX_W-1:0] w_idx
);
    logic take_b;

    // Side a always carries the lower lane number; b wins only when strictly larger.
    always_comb begin
        take_b = (b_val > a_val);
        w_val  = take_b ? b_val : a_val;
        w_idx  = take_b ? b_idx : a_idx;
    end
endmodule

// File: rtl/maxidx_tree.sv
module maxidx_tree
    import maxidx_pkg::*;
#(
    parameter int W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [LANES*W-1:0] in_vals,
    output logic               out_valid,
    output logic [W-1:0]       out_max,
    output logic [IDX_W-1:0]   out_idx
);
    localparam int N1 = LANES / 2;
    localparam int N2 = LANES / 4;

    typedef struct packed {
        logic [W-1:0]     val;
        logic [IDX_W-1:0] idx;
    } pair_t;

    typedef struct packed {
        logic             vld1;
        pair_t [N1-1:0]   lv1;
        logic             vld2;
        pair_t [N2-1:0]   lv2;
        logic             vld3;
        pair_t            lv3;
    } pipe_t;

    pipe_t st_d, st_q;

    logic [LANES-1:0][W-1:0]     leaf_val;
    logic [LANES-1:0][IDX_W-1:0] leaf_idx;
    logic [N1-1:0][W-1:0]        n1_val;
    logic [N1-1:0][IDX_W-1:0]    n1_idx;
    logic [N2-1:0][W-1:0]        n2_val;
    logic [N2-1:0][IDX_W-1:0]    n2_idx;
    logic [W-1:0]                n3_val;
    logic [IDX_W-1:0]            n3_idx;

    always_comb begin
        for (int k = 0; k < LANES; k++) begin
            leaf_val[k] = in_vals[k*W +: W];
            leaf_idx[k] = IDX_W'(k);
        end
    end

    generate
        for (genvar g = 0; g < N1; g++) begin : g_lvl1
            maxidx_node #(.W(W)) u_node (
                .a_val (leaf_val[2*g]),
                .a_idx (leaf_idx[2*g]),
                .b_val (leaf_val[2*g+1]),
                .b_idx (leaf_idx[2*g+1]),
                .w_val (n1_val[g]),
                .w_idx (n1_idx[g])
            );
        end
        for (genvar g = 0; g < N2; g++) begin : g_lvl2
            maxidx_node #(.W(W)) u_node (
                .a_val (st_q.lv1[2*g].val),
                .a_idx (st_q.lv1[2*g].idx),
                .b_val (st_q.lv1[2*g+1].val),
                .b_idx (st_q.lv1[2*g+1].idx),
                .w_val (n2_val[g]),
                .w_idx (n2_idx[g])
            );
        end
    endgenerate

    maxidx_node #(.W(W)) u_root (
        .a_val (st_q.lv2[0].val),
        .a_idx (st_q.lv2[0].idx),
        .b_val (st_q.lv2[1].val),
        .b_idx (st_q.lv2[1].idx),
        .w_val (n3_val),
        .w_idx (n3_idx)
    );

    always_comb begin
        st_d      = st_q;
        st_d.vld1 = in_valid;
        st_d.vld2 = st_q.vld1;
        st_d.vld3 = st_q.vld2;
        if (in_valid) begin
            for (int k = 0; k < N1; k++) begin
                st_d.lv1[k].val = n1_val[k];
                st_d.lv1[k].idx = n1_idx[k];
            end
        end
        if (st_q.vld1) begin
            for (int k = 0; k < N2; k++) begin
                st_d.lv2[k].val = n2_val[k];
                st_d.lv2[k].idx = n2_idx[k];
            end
        end
        if (st_q.vld2) begin
            st_d.lv3.val = n3_val;
            st_d.lv3.idx = n3_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld3;
    assign out_max   = st_q.lv3.val;
    assign out_idx   = st_q.lv3.idx;

    // Edges seen since reset, saturating, so the latency check never looks before reset.
    logic [1:0] age_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             age_q <= '0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    // R4
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    // R1
    lvl2_dominates_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.vld1 |=> (st_q.lv2[0].val >= $past(st_q.lv1[0].val)) &&
                      (st_q.lv2[0].val >= $past(st_q.lv1[1].val)));

    // R3
    lvl2_tie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.vld1 && (st_q.lv1[0].val == st_q.lv1[1].val))
        |=> (st_q.lv2[0].idx == $past(st_q.lv1[0].idx)));

    // R2
    root_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.vld2 |=> (out_idx == $past(st_q.lv2[0].idx)) ||
                      (out_idx == $past(st_q.lv2[1].idx)));
endmodule

// File: rtl/maxidx_scan.sv
module maxidx_scan
    import maxidx_pkg::*;
#(
    parameter int W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [LANES*W-1:0] in_vals,
    output logic               out_valid,
    output logic [W-1:0]       out_max,
    output logic [IDX_W-1:0]   out_idx
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(LANES - 1);

    typedef struct packed {
        logic             busy;
        logic [IDX_W-1:0] cnt;
        logic [W-1:0]     best;
        logic [IDX_W-1:0] best_idx;
        logic             done;
    } scan_t;

    scan_t st_d, st_q;

    logic [W-1:0]     sel_val;
    logic [W-1:0]     base_val;
    logic [IDX_W-1:0] base_idx;
    logic             step;

    always_comb begin
        sel_val = '0;
        for (int k = 0; k < LANES; k++) begin
            if (st_q.cnt == IDX_W'(k)) sel_val = in_vals[k*W +: W];
        end
    end

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        step      = st_q.busy || in_valid;
        // On lane 0 the running best restarts from the smallest value.
        base_val  = (st_q.cnt == '0) ? '0 : st_q.best;
        base_idx  = (st_q.cnt == '0) ? '0 : st_q.best_idx;
        if (step) begin
            if (sel_val > base_val) begin
                st_d.best     = sel_val;
                st_d.best_idx = st_q.cnt;
            end else begin
                st_d.best     = base_val;
                st_d.best_idx = base_idx;
            end
            if (st_q.cnt == LAST) begin
                st_d.cnt  = '0;
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end else begin
                st_d.cnt  = st_q.cnt + 1'b1;
                st_d.busy = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.done;
    assign out_max   = st_q.best;
    assign out_idx   = st_q.best_idx;

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R7
    done_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($past(st_q.busy) && ($past(st_q.cnt) == LAST)));

    // R8
    cnt_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |=> (st_q.cnt == (($past(st_q.cnt) == LAST) ? '0 : $past(st_q.cnt) + 1'b1)));

    // R9
    best_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |=> (st_q.best >= $past(st_q.best)));
endmodule

// File: rtl/maxidx_top.sv
module maxidx_top
    import maxidx_pkg::*;
#(
    parameter int W          = 16,
    parameter bit SEQUENTIAL = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [LANES*W-1:0] in_vals,
    output logic               out_valid,
    output logic [W-1:0]       out_max,
    output logic [IDX_W-1:0]   out_idx
);
    generate
        if (SEQUENTIAL) begin : g_scan
            maxidx_scan #(.W(W)) u_core (
                .clk       (clk),
                .rst_n     (rst_n),
                .in_valid  (in_valid),
                .in_vals   (in_vals),
                .out_valid (out_valid),
                .out_max   (out_max),
                .out_idx   (out_idx)
            );
        end else begin : g_tree
            maxidx_tree #(.W(W)) u_core (
                .clk       (clk),
                .rst_n     (rst_n),
                .in_valid  (in_valid),
                .in_vals   (in_vals),
                .out_valid (out_valid),
                .out_max   (out_max),
                .out_idx   (out_idx)
            );
        end
    endgenerate
endmodule

// File: tb/maxidx_top_tb.sv
`timescale 1ns/1ps
module maxidx_top_tb;
    import maxidx_pkg::*;
    localparam int W = 16;
    localparam int BUS = LANES * W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic           t_iv = 1'b0, s_iv = 1'b0;
    logic [BUS-1:0] t_vals = '0, s_vals = '0;
    logic           t_ov, s_ov;
    logic [W-1:0]   t_max, s_max;
    logic [2:0]     t_idx, s_idx;

    maxidx_top #(.W(W), .SEQUENTIAL(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(t_iv), .in_vals(t_vals),
        .out_valid(t_ov), .out_max(t_max), .out_idx(t_idx));

    maxidx_top #(.W(W), .SEQUENTIAL(1'b1)) u_dut_seq (
        .clk(clk), .rst_n(rst_n), .in_valid(s_iv), .in_vals(s_vals),
        .out_valid(s_ov), .out_max(s_max), .out_idx(s_idx));

    typedef struct {
        logic [W-1:0] m;
        logic [2:0]   i;
        int           due;
        string        tag;
    } exp_t;

    exp_t q_tree[$];
    exp_t q_scan[$];
    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    bit   mon_on = 1'b0;
    bit   done_t = 1'b0, done_s = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic exp_t model(input logic [BUS-1:0] v);
        exp_t e;
        e.m = v[0 +: W];
        e.i = 3'd0;
        for (int k = 1; k < LANES; k++) begin
            if (v[k*W +: W] > e.m) begin
                e.m = v[k*W +: W];
                e.i = 3'(k);
            end
        end
        return e;
    endfunction

    function automatic logic [BUS-1:0] fill(input logic [W-1:0] x);
        logic [BUS-1:0] v;
        for (int k = 0; k < LANES; k++) v[k*W +: W] = x;
        return v;
    endfunction

    function automatic logic [BUS-1:0] ramp(input bit up);
        logic [BUS-1:0] v;
        for (int k = 0; k < LANES; k++)
            v[k*W +: W] = W'(up ? (k * 100 + 5) : ((LANES - k) * 100 + 5));
        return v;
    endfunction

    function automatic logic [BUS-1:0] rnd();
        logic [BUS-1:0] v;
        for (int k = 0; k < LANES; k++) v[k*W +: W] = W'($urandom);
        return v;
    endfunction

    function automatic logic [BUS-1:0] pattern(input int p);
        logic [BUS-1:0] v;
        case (p)
            0: v = ramp(1'b1);                 // R1 R2: winner at lane 7
            1: v = ramp(1'b0);                 // R1 R2: winner at lane 0
            2: v = fill(16'h1234);             // R3: all equal
            3: v = fill(16'h0000);             // R3: all zero
            4: v = fill(16'hFFFF);             // R3: all full scale
            5: begin                           // R3: twin peaks at lanes 3 and 6
                v = fill(16'h0010);
                v[3*W +: W] = 16'h8000;
                v[6*W +: W] = 16'h8000;
            end
            6: begin                           // R1: one LSB above the rest, lane 5
                v = fill(16'h0000);
                v[5*W +: W] = 16'h0001;
            end
            default: begin                     // R1: full scale next to one below it
                v = fill(16'hFFFE);
                v[7*W +: W] = 16'hFFFF;
            end
        endcase
        return v;
    endfunction

    task automatic tree_send(input logic [BUS-1:0] v, input string tag);
        exp_t e;
        e = model(v);
        e.due = cyc + 3;
        e.tag = tag;
        q_tree.push_back(e);
        t_vals = v;
        t_iv = 1'b1;
        @(negedge clk);
        t_iv = 1'b0;
    endtask

    task automatic scan_send(input logic [BUS-1:0] v, input string tag, input bit poke);
        exp_t e;
        e = model(v);
        e.due = cyc + 8;
        e.tag = tag;
        q_scan.push_back(e);
        s_vals = v;
        s_iv = 1'b1;
        @(negedge clk);
        for (int k = 1; k < 8; k++) begin
            s_iv = (poke && k >= 1 && k <= 5);
            @(negedge clk);
        end
        s_iv = 1'b0;
    endtask

    // Monitor: pops an expected item when it is due, otherwise demands a quiet strobe.
    always @(negedge clk) begin
        if (mon_on) begin
            if (q_tree.size() != 0 && q_tree[0].due == cyc) begin
                exp_t e;
                e = q_tree.pop_front();
                chk({e.tag, " R4 valid"}, 32'(t_ov), 32'd1);
                chk({e.tag, " max"}, 32'(t_max), 32'(e.m));
                chk({e.tag, " idx"}, 32'(t_idx), 32'(e.i));
            end else begin
                chk("R6 idle strobe", 32'(t_ov), 32'd0);
            end
            if (q_scan.size() != 0 && q_scan[0].due == cyc) begin
                exp_t e;
                e = q_scan.pop_front();
                chk({e.tag, " R7 valid"}, 32'(s_ov), 32'd1);
                chk({e.tag, " max"}, 32'(s_max), 32'(e.m));
                chk({e.tag, " idx"}, 32'(s_idx), 32'(e.i));
            end else begin
                chk("R7 R8 idle strobe", 32'(s_ov), 32'd0);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: state under reset
        chk("R10 tree valid", 32'(t_ov), 32'd0);
        chk("R10 tree max", 32'(t_max), 32'd0);
        chk("R10 tree idx", 32'(t_idx), 32'd0);
        chk("R10 scan valid", 32'(s_ov), 32'd0);
        chk("R10 scan max", 32'(s_max), 32'd0);
        chk("R10 scan idx", 32'(s_idx), 32'd0);
        rst_n = 1'b1;
        mon_on = 1'b1;
        @(negedge clk);

        fork
            begin : tree_drv
                for (int p = 0; p < 8; p++) begin
                    tree_send(pattern(p), "R1 R2 R3");
                    repeat (p % 3) @(negedge clk);   // R6: idle gaps
                end
                for (int n = 0; n < 24; n++) tree_send(rnd(), "R5 R1 R2");
                repeat (4) @(negedge clk);
                for (int p = 0; p < 8; p++) tree_send(pattern(p), "R5 R3");
                done_t = 1'b1;
            end
            begin : scan_drv
                for (int p = 0; p < 8; p++) begin
                    scan_send(pattern(p), "R1 R2 R3 seq", 1'b0);
                    repeat (p % 2) @(negedge clk);
                end
                scan_send(fill(16'hFFFF), "R9 big", 1'b0);
                scan_send(fill(16'h0000), "R9 zero after big", 1'b0);
                for (int n = 0; n < 4; n++) scan_send(rnd(), "R8 poked", 1'b1);
                for (int n = 0; n < 4; n++) scan_send(rnd(), "R8 back-to-back", 1'b0);
                done_s = 1'b1;
            end
        join

        repeat (12) @(negedge clk);
        chk("R4 tree results outstanding", 32'(q_tree.size()), 32'd0);
        chk("R7 scan results outstanding", 32'(q_scan.size()), 32'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule